// File: doc/BRIEF.md
# Disc DMA Window Controller

This block is one DMA channel that carries data from an ATA-style disc drive into system memory. Software sets a 32-byte aligned destination through the start-address register, sets a byte count through the length register and pulses a start strobe. Before any data moves, the block checks that the first and the last 32-byte unit of the transfer lie inside the same entry of a fixed list of permitted address windows. A destination that fails this check is never written. The block reports it with an illegal-address interrupt pulse instead.

An accepted transfer runs as a series of 32-byte bursts. Each burst starts when the drive raises its DMA request. The block answers with an active-low acknowledge and moves the burst beat by beat onto a simple write port that carries an address, data and a last-beat flag. A working address counter and a remaining-byte count step by 32 per burst. The block gives one-cycle interrupt pulses for normal completion, for an illegal destination, for a drive that still requests data after the programmed length, and for a ROM or flash access that arrives while the channel is busy.

Top module: `disc_dma_ctrl`

## Requirements
- R1: The start-address register keeps bits [28:5] of a write. Read back through `start_addr_rd`, bits [31:29] and [4:0] are always zero. The length register ignores bits [4:0] of a write, so the length is a whole number of 32-byte units.
- R2: Reset does not clear the start-address register, and the hardware never changes it. It changes only on a register write.
- R3: Each burst puts 32/(DW/8) beats on the write port (8 beats for the default DW=32). Beat addresses rise by DW/8 from the working address. `bus_wlast` is high on the final beat only. The working address rises by 32 after every burst. Each beat carries the drive data sampled on the edge that produced it.
- R4: A start is legal only when the start address and the end address (start + length − 32, or the start itself for a zero length) fall in the same one of these inclusive windows: 0x0C000000–0x0CFFFFE0, 0x00700000–0x00707FE0, 0x14000000–0x17FFFFE0, 0x04000000–0x047FFFE0, 0x00800000–0x009FFFE0, 0x0E000000–0x0EFFFFE0, 0x05000000–0x057FFFE0, 0x01000000–0x01FFFFE0, 0x06000000–0x067FFFE0, 0x02700000–0x02FFFFE0, 0x07000000–0x077FFFE0, 0x03000000–0x03FFFFE0.
- R5: After an illegal start, `irq_illegal` is high for exactly the one cycle after the start edge. `busy` stays low, and no acknowledge or bus beat follows.
- R6: `irq_end` is high for one cycle. It arrives together with the final beat of the final burst, when `busy` falls and `bytes_left` reads zero. A legal start with zero length raises `irq_end` in the cycle after the start and moves no data.
- R7: If `drv_dreq` is high on the first clock edge after completion, `irq_overrun` is high for one cycle after that edge. If the request is low there, no overrun is reported.
- R8: `rom_access` seen on an edge while `busy` is high gives a one-cycle `irq_romacc` after that edge. While idle, `rom_access` has no effect.
- R9: `drv_dack_n` goes low the cycle after an edge that sees `drv_dreq` high while busy and not already in a burst. It stays low for exactly one burst's beat count, and never while idle.
- R10: `bytes_left` is loaded with the length at an accepted start and falls by 32 after each burst. A start strobe while busy is ignored: the running transfer keeps its address and count.
- R11: After synchronous reset, `busy`, `bus_wvalid` and every interrupt are low, `drv_dack_n` is high and `bytes_left` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr_we | input | 1 | Write strobe for the start-address register |
| reg_len_we | input | 1 | Write strobe for the length register |
| reg_wdata | input | 32 | Register write data |
| go | input | 1 | Start strobe |
| start_addr_rd | output | 32 | Start-address register read-back |
| bytes_left | output | LW | Bytes still to move |
| busy | output | 1 | Transfer in progress |
| drv_dreq | input | 1 | Drive DMA request |
| drv_dack_n | output | 1 | Drive DMA acknowledge, active low |
| drv_data | input | DW | Drive data beat |
| rom_access | input | 1 | ROM or flash access attempt |
| bus_wvalid | output | 1 | Write beat valid |
| bus_waddr | output | 32 | Write beat byte address |
| bus_wdata | output | DW | Write beat data |
| bus_wlast | output | 1 | Final beat of a burst |
| irq_end | output | 1 | Completion pulse |
| irq_illegal | output | 1 | Illegal destination pulse |
| irq_overrun | output | 1 | Drive overrun pulse |
| irq_romacc | output | 1 | ROM/flash access during DMA pulse |

## Verification
The illegal-address pulse, the busy flag, the loaded byte count and the zero-length completion are all due one cycle after the edge that samples `go`. The acknowledge falls one cycle after a request is seen. Each bus beat appears one cycle after the edge that sampled its drive data. The completion pulse comes with the final beat, and the overrun pulse follows one cycle later. `irq_romacc` lags its cause by one edge. The bench drives every input on the falling edge and reads results on the next falling edge, so each check lands exactly one register stage after its cause.

// File: rtl/disc_dma_pkg.sv
package disc_dma_pkg;
  localparam int AW          = 32;
  localparam int NWIN        = 12;
  localparam int BURST_BYTES = 32;

  // Permitted destination windows: first and last 32-byte unit (inclusive)
  localparam logic [AW-1:0] WIN_LO [NWIN] = '{
    32'h0C00_0000, 32'h0070_0000, 32'h1400_0000, 32'h0400_0000,
    32'h0080_0000, 32'h0E00_0000, 32'h0500_0000, 32'h0100_0000,
    32'h0600_0000, 32'h0270_0000, 32'h0700_0000, 32'h0300_0000};
  localparam logic [AW-1:0] WIN_HI [NWIN] = '{
    32'h0CFF_FFE0, 32'h0070_7FE0, 32'h17FF_FFE0, 32'h047F_FFE0,
    32'h009F_FFE0, 32'h0EFF_FFE0, 32'h057F_FFE0, 32'h01FF_FFE0,
    32'h067F_FFE0, 32'h02FF_FFE0, 32'h077F_FFE0, 32'h03FF_FFE0};
endpackage

// File: rtl/dma_win_check.sv
module dma_win_check
  import disc_dma_pkg::*;
(
  input  logic [AW-1:0]   addr,
  output logic [NWIN-1:0] hit
);
  for (genvar i = 0; i < NWIN; i++) begin : g_win
    assign hit[i] = (addr >= WIN_LO[i]) && (addr <= WIN_HI[i]);
  end
endmodule

// File: rtl/dma_xfer_core.sv
module dma_xfer_core
  import disc_dma_pkg::*;
#(
  parameter int DW = 32,
  parameter int LW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          legal,
  input  logic [AW-1:0] start_addr,
  input  logic [LW-1:0] len,
  input  logic          drv_dreq,
  input  logic [DW-1:0] drv_data,
  output logic          busy,
  output logic          drv_dack_n,
  output logic [LW-1:0] bytes_left,
  output logic          bus_wvalid,
  output logic [AW-1:0] bus_waddr,
  output logic [DW-1:0] bus_wdata,
  output logic          bus_wlast,
  output logic          accept,
  output logic          ev_done
);
  localparam int BYTES_PER_BEAT = DW / 8;
  localparam int BEATS          = BURST_BYTES / BYTES_PER_BEAT;
  localparam int BW             = (BEATS > 1) ? $clog2(BEATS) : 1;

  logic          in_burst_q;
  logic [BW-1:0] beat_q;
  logic [AW-1:0] cur_q;
  logic          last_beat;

  assign accept    = go && !busy;
  assign last_beat = in_burst_q && (beat_q == BW'(BEATS - 1));
  assign ev_done   = (last_beat && (bytes_left == LW'(BURST_BYTES))) ||
                     (accept && legal && (len == '0));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      in_burst_q <= 1'b0;
      beat_q     <= '0;
      cur_q      <= '0;
      bytes_left <= '0;
      drv_dack_n <= 1'b1;
      bus_wvalid <= 1'b0;
      bus_wlast  <= 1'b0;
      bus_waddr  <= '0;
      bus_wdata  <= '0;
    end else begin
      bus_wvalid <= 1'b0;
      bus_wlast  <= 1'b0;
      if (accept) begin
        if (legal && (len != '0)) begin
          busy       <= 1'b1;
          cur_q      <= start_addr;
          bytes_left <= len;
        end
      end else if (busy && !in_burst_q && drv_dreq) begin
        in_burst_q <= 1'b1;
        drv_dack_n <= 1'b0;
        beat_q     <= '0;
      end else if (in_burst_q) begin
        bus_wvalid <= 1'b1;
        bus_wdata  <= drv_data;
        bus_waddr  <= cur_q + AW'(beat_q) * AW'(BYTES_PER_BEAT);
        bus_wlast  <= last_beat;
        beat_q     <= beat_q + 1'b1;
        if (last_beat) begin
          in_burst_q <= 1'b0;
          drv_dack_n <= 1'b1;
          cur_q      <= cur_q + AW'(BURST_BYTES);
          bytes_left <= bytes_left - LW'(BURST_BYTES);
          if (bytes_left == LW'(BURST_BYTES)) busy <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/dma_irq_gen.sv
module dma_irq_gen (
  input  logic clk,
  input  logic rst,
  input  logic accept,
  input  logic legal,
  input  logic ev_done,
  input  logic busy,
  input  logic drv_dreq,
  input  logic rom_access,
  output logic irq_end,
  output logic irq_illegal,
  output logic irq_overrun,
  output logic irq_romacc
);
  logic armed_q;   // set by completion, watches the next edge for a stray request
  logic ev_over;

  assign ev_over = armed_q && !busy && !accept && drv_dreq;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q     <= 1'b0;
      irq_end     <= 1'b0;
      irq_illegal <= 1'b0;
      irq_overrun <= 1'b0;
      irq_romacc  <= 1'b0;
    end else begin
      irq_end     <= ev_done;
      irq_illegal <= accept && !legal;
      irq_overrun <= ev_over;
      irq_romacc  <= rom_access && busy;
      armed_q     <= ev_done;
    end
  end
endmodule

// File: rtl/disc_dma_ctrl.sv
module disc_dma_ctrl
  import disc_dma_pkg::*;
#(
  parameter int DW = 32,
  parameter int LW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_addr_we,
  input  logic          reg_len_we,
  input  logic [31:0]   reg_wdata,
  input  logic          go,
  output logic [31:0]   start_addr_rd,
  output logic [LW-1:0] bytes_left,
  output logic          busy,
  input  logic          drv_dreq,
  output logic          drv_dack_n,
  input  logic [DW-1:0] drv_data,
  input  logic          rom_access,
  output logic          bus_wvalid,
  output logic [31:0]   bus_waddr,
  output logic [DW-1:0] bus_wdata,
  output logic          bus_wlast,
  output logic          irq_end,
  output logic          irq_illegal,
  output logic          irq_overrun,
  output logic          irq_romacc
);
  logic [28:5]     sa_q;    // no reset: keeps its value across reset
  logic [LW-1:0]   len_q;
  logic [AW-1:0]   sa_full, end_addr;
  logic [NWIN-1:0] hit_s, hit_e;
  logic            legal, accept, ev_done;
  logic            unused_bits;

  assign unused_bits = ^{reg_wdata[31:29], reg_wdata[4:0]};

  always_ff @(posedge clk) begin
    if (reg_addr_we) sa_q <= reg_wdata[28:5];
  end

  always_ff @(posedge clk) begin
    if (rst)             len_q <= '0;
    else if (reg_len_we) len_q <= {reg_wdata[LW-1:5], 5'b0};
  end

  assign sa_full       = {3'b000, sa_q, 5'b00000};
  assign start_addr_rd = sa_full;
  assign end_addr      = (len_q == '0) ? sa_full
                                       : sa_full + AW'(len_q) - AW'(BURST_BYTES);
  assign legal         = |(hit_s & hit_e);

  dma_win_check u_win_s (.addr(sa_full),  .hit(hit_s));
  dma_win_check u_win_e (.addr(end_addr), .hit(hit_e));

  dma_xfer_core #(.DW(DW), .LW(LW)) u_core (
    .clk, .rst, .go, .legal,
    .start_addr(sa_full), .len(len_q),
    .drv_dreq, .drv_data, .busy, .drv_dack_n, .bytes_left,
    .bus_wvalid, .bus_waddr, .bus_wdata, .bus_wlast,
    .accept, .ev_done
  );

  dma_irq_gen u_irq (
    .clk, .rst, .accept, .legal, .ev_done, .busy, .drv_dreq, .rom_access,
    .irq_end, .irq_illegal, .irq_overrun, .irq_romacc
  );
endmodule

// File: rtl/disc_dma_ctrl_chk.sv
module disc_dma_ctrl_chk #(
  parameter int LW = 24
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic [LW-1:0] bytes_left,
  input logic          drv_dack_n,
  input logic          rom_access,
  input logic          bus_wvalid,
  input logic          irq_end,
  input logic          irq_illegal,
  input logic          irq_romacc
);
  a_r5_illegal_idle: assert property (@(posedge clk) disable iff (rst)
    irq_illegal |-> (!busy && drv_dack_n));
  a_r6_end_clears: assert property (@(posedge clk) disable iff (rst)
    irq_end |-> (!busy && bytes_left == '0));
  a_r6_single_cause: assert property (@(posedge clk) disable iff (rst)
    $onehot0({irq_end, irq_illegal}));
  a_r9_dack_needs_busy: assert property (@(posedge clk) disable iff (rst)
    !drv_dack_n |-> busy);
  a_r3_beat_after_ack: assert property (@(posedge clk) disable iff (rst)
    bus_wvalid |-> $past(!drv_dack_n));
  a_r8_rom_event: assert property (@(posedge clk) disable iff (rst)
    (rom_access && busy) |=> irq_romacc);
  a_r10_left_steps: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |->
      (bytes_left == $past(bytes_left) || bytes_left == $past(bytes_left) - LW'(32)));
endmodule

bind disc_dma_ctrl disc_dma_ctrl_chk #(.LW(LW)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .bytes_left(bytes_left),
  .drv_dack_n(drv_dack_n), .rom_access(rom_access), .bus_wvalid(bus_wvalid),
  .irq_end(irq_end), .irq_illegal(irq_illegal), .irq_romacc(irq_romacc)
);

// File: tb/disc_dma_ctrl_tb.sv
`timescale 1ns/1ps
module disc_dma_ctrl_tb;
  localparam int DW = 32;
  localparam int LW = 24;
  localparam int BEATS = 32 / (DW / 8);
  localparam int NV = 10;

  // vector table: raw address write, raw length write, expected legality (R4)
  localparam logic [31:0] V_ADDR [NV] = '{
    32'h0070_7FC0, 32'h0070_7FE0, 32'h0060_0000, 32'h047F_FFE0, 32'hEC00_0000,
    32'h1400_0000, 32'h17FF_FFE0, 32'h0280_001F, 32'h1800_0000, 32'h0080_0000};
  localparam logic [31:0] V_LEN [NV] = '{
    32'd64, 32'd64, 32'd32, 32'd64, 32'd96, 32'd32, 32'd32, 32'h5F, 32'd32, 32'd0};
  localparam bit V_OK [NV] = '{1, 0, 0, 0, 1, 1, 1, 1, 0, 1};

  logic clk = 0, rst = 1;
  logic reg_addr_we = 0, reg_len_we = 0, go = 0, drv_dreq = 0, rom_access = 0;
  logic [31:0] reg_wdata = '0;
  logic [DW-1:0] drv_data = '0;
  logic [31:0] start_addr_rd, bus_waddr;
  logic [LW-1:0] bytes_left;
  logic busy, drv_dack_n, bus_wvalid, bus_wlast;
  logic [DW-1:0] bus_wdata;
  logic irq_end, irq_illegal, irq_overrun, irq_romacc;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [DW-1:0] pat = 32'h1357_9BDF;

  always #5 clk = ~clk;

  disc_dma_ctrl #(.DW(DW), .LW(LW)) u_dut (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic prog(input logic [31:0] a, input logic [31:0] l);
    @(negedge clk); reg_addr_we = 1; reg_wdata = a;
    @(negedge clk); reg_addr_we = 0; reg_len_we = 1; reg_wdata = l;
    @(negedge clk); reg_len_we = 0; go = 1;
    @(negedge clk); go = 0;
  endtask

  // drive request high until completion, checking every beat (R3, R9)
  task automatic stream(input logic [31:0] ea, input int el, output bit seen_end);
    int beats = 0, errs = 0, dack_lo = 0;
    logic [31:0] exp_addr = ea;
    logic [DW-1:0] sent;
    seen_end = 0;
    drv_dreq = 1;
    for (int c = 0; c < 4000 && !seen_end; c++) begin
      pat = {pat[30:0], pat[31] ^ pat[21] ^ pat[1] ^ pat[0]} + 32'd7;
      drv_data = pat; sent = pat;
      @(negedge clk);
      if (!drv_dack_n) dack_lo++;
      if (bus_wvalid) begin
        if (bus_waddr != exp_addr || bus_wdata != sent ||
            bus_wlast != ((beats % BEATS) == BEATS - 1)) errs++;
        exp_addr += DW / 8;
        beats++;
      end
      if (irq_end) seen_end = 1;
    end
    chk(errs == 0, "R3 beat address/data/last", errs, 0);
    chk(beats == el / (DW / 8), "R3 beat count", beats, el / (DW / 8));
    chk(dack_lo == beats, "R9 acknowledge low cycles", dack_lo, beats);
    chk(seen_end && !busy && bytes_left == 0, "R6 completion", {busy, bytes_left}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    bit seen;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!busy && drv_dack_n && !bus_wvalid && bytes_left == 0 &&
        !irq_end && !irq_illegal && !irq_overrun && !irq_romacc,
        "R11 reset state", {busy, drv_dack_n, bus_wvalid}, 3'b010);

    // table walk
    for (int v = 0; v < NV; v++) begin
      logic [31:0] ea, el;
      ea = V_ADDR[v] & 32'h1FFF_FFE0;
      el = V_LEN[v] & ~32'h1F;
      prog(V_ADDR[v], V_LEN[v]);
      chk(start_addr_rd == ea, "R1 start register read-back", start_addr_rd, ea);
      if (!V_OK[v]) begin
        chk(irq_illegal && !busy, "R4 R5 illegal start flagged", {irq_illegal, busy}, 2'b10);
        @(negedge clk);
        chk(!irq_illegal && !bus_wvalid && drv_dack_n && !busy,
            "R5 no transfer after illegal start", {irq_illegal, bus_wvalid, drv_dack_n}, 3'b001);
      end else if (el == 0) begin
        chk(irq_end && !busy && !bus_wvalid, "R6 zero length ends at once", {irq_end, busy}, 2'b10);
      end else begin
        chk(busy && bytes_left == el[LW-1:0], "R4 R10 legal start loads count", bytes_left, el);
        stream(ea, el, seen);
        @(negedge clk);
        chk(irq_overrun, "R7 overrun after completion", irq_overrun, 1);
        drv_dreq = 0;
        @(negedge clk);
        chk(!irq_overrun && drv_dack_n, "R7 overrun single pulse", irq_overrun, 0);
      end
    end

    // directed: ROM access while busy, start ignored while busy, register untouched
    prog(32'h0C00_0100, 32'd64);
    @(negedge clk); rom_access = 1;
    @(negedge clk); rom_access = 0;
    chk(irq_romacc, "R8 rom access while busy", irq_romacc, 1);
    @(negedge clk);
    chk(!irq_romacc, "R8 rom pulse ends", irq_romacc, 0);
    @(negedge clk); reg_addr_we = 1; reg_wdata = 32'h0500_0000;
    @(negedge clk); reg_addr_we = 0; go = 1;
    @(negedge clk); go = 0;
    chk(busy && bytes_left == 64 && !irq_illegal, "R10 start while busy ignored", bytes_left, 64);
    chk(start_addr_rd == 32'h0500_0000, "R1 register write while busy", start_addr_rd, 32'h0500_0000);
    stream(32'h0C00_0100, 64, seen);
    drv_dreq = 0;
    @(negedge clk);
    chk(!irq_overrun, "R7 no overrun when request drops", irq_overrun, 0);
    chk(start_addr_rd == 32'h0500_0000, "R2 hardware leaves start register", start_addr_rd, 32'h0500_0000);
    rom_access = 1;
    @(negedge clk); rom_access = 0;
    @(negedge clk);
    chk(!irq_romacc, "R8 rom access while idle ignored", irq_romacc, 0);

    // reset keeps the start register
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(start_addr_rd == 32'h0500_0000, "R2 start register survives reset", start_addr_rd, 32'h0500_0000);
    chk(bytes_left == 0 && !busy && drv_dack_n, "R11 state after second reset", bytes_left, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule